// File: doc/BRIEF.md
# Byte-Serial SPI Controller with Self-Clearing Status

This block is a byte-wide SPI port that works either as bus master or as slave. Software reaches it through four small register locations. The data location serves both directions: a write feeds the shifter and a read returns the last byte received. A status location reports completion, write collision and mode fault, and all three flags drop when it is read. A control location selects enable, role, clock polarity, clock phase and interrupt enable. A divider location sets the master SCK rate.

As master, a write to the data location starts an 8-bit, MSB-first exchange, and the block generates SCK itself. As slave, the block follows an external SCK while its select input is low. A master that sees its select input pulled low by another master gives up mastership and releases its outputs.

Top module: `spi_port`

## Requirements
- R1: After reset the status, control and divider locations read 0x00, `irq` is low, and `sckOe`, `mosiOe` and `misoOe` are low.
- R2: The status byte carries transfer-done in bit 7, write-collision in bit 6 and mode-fault in bit 4. Bits 5 and 3..0 always read 0.
- R3: In master mode, a data write (address 0) while idle starts a transfer of 8 bits, MSB first. Each SCK half-period lasts divider+1 clock cycles. The done flag is visible 16*(divider+1)+1 cycles after the write cycle.
- R4: A status read (address 1) clears bits 7, 6 and 4. A flag set in the same cycle as the read stays set.
- R5: A data write during a transfer sets the collision flag and is ignored. The byte in flight, and the byte later received, are unchanged.
- R6: Data address 0 is shared: a write goes to the shifter and a read returns the receive buffer.
- R7: If the block is an enabled master and the select input `ssIn` goes low, the mode-fault flag is set and the master bit (control bit 1) is cleared. `sckOe` and `mosiOe` drop, and the aborted transfer never sets done.
- R8: When a transfer finishes, in master or slave mode, the received byte enters the receive buffer in the same cycle that the done flag is set.
- R9: `irq` is high while done is set and interrupt enable (control bit 4) is set. It is low after a status read and stays low when interrupt enable is clear.
- R10: Control bit 2 (CPOL) sets the idle SCK level. With control bit 3 (CPHA) at 0, data is sampled on the leading edge. With CPHA at 1, data is sampled on the trailing edge.
- R11: In slave mode (control bit 0 set, bit 1 clear), with `ssIn` low, the block drives `misoOut` with `misoOe` high, shifts on edges of `sckIn`, and sets done after 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected location |
| irq | output | 1 | Level interrupt |
| sckOut | output | 1 | Master serial clock |
| sckOe | output | 1 | Enable for driving SCK |
| mosiOut | output | 1 | Master data out |
| mosiOe | output | 1 | Enable for driving MOSI |
| misoIn | input | 1 | Master data in |
| sckIn | input | 1 | Slave serial clock |
| mosiIn | input | 1 | Slave data in |
| misoOut | output | 1 | Slave data out |
| misoOe | output | 1 | Enable for driving MISO |
| ssIn | input | 1 | Active-low select; in master mode a low level is a mode fault |

## Verification
Master transfers run in all four CPOL/CPHA combinations, each with a different byte (A5, 3C, 81, 7E) and a different divider. A wrong edge choice, a wrong bit order or a wrong half-period length each shows up as a separate mismatch. MISO is looped back to MOSI, so the receive buffer must equal the byte sent. An independent decoder of the MOSI line checks the byte on the wire. A second write during a transfer, a run with interrupts off, and a select pulled low mid-transfer show whether each flag and the irq level respond only to their own cause. A bench-driven slave exchange with different bytes in each direction checks the receive path and the MISO path apart from the master timing.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BUS_W = 8;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  // control register layout, bit 4 down to bit 0
  typedef struct packed {
    logic irqEn;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
  } ctrlCfg_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic capture;
    logic mergeLatch;
  } dpStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} seqState_t;
endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp import spi_port_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] loadData,
  input  logic              serialIn,
  output logic              serialOut,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shiftReg;
  logic              bitLatch;

  assign serialOut = shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      bitLatch <= 1'b0;
      rxData   <= '0;
    end else begin
      if (stb.load)
        shiftReg <= loadData;
      else if (stb.shift)
        shiftReg <= {shiftReg[DATA_W-2:0], bitLatch};
      if (stb.sample)
        bitLatch <= serialIn;
      if (stb.capture)
        rxData <= stb.mergeLatch ? {shiftReg[DATA_W-2:0], bitLatch} : shiftReg;
    end
  end

  // R5: a new byte never enters the shifter in a cycle that moves bits
  a_r5_load_not_during_shift: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |-> !(stb.shift || stb.sample || stb.capture));
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl import spi_port_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             sckIn,
  input  logic             ssIn,
  output dpStrobe_t        stb,
  output ctrlCfg_t         cfg,
  output logic [DIV_W-1:0] divVal,
  output logic [BUS_W-1:0] statusByte,
  output logic             irq,
  output logic             sckOut,
  output logic             masterDrive,
  output logic             slaveDrive
);
  localparam int IDX_W = $clog2(2 * DATA_W);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(2 * DATA_W - 1);

  seqState_t        state;
  logic [IDX_W-1:0] edgeIdx;
  logic [DIV_W-1:0] divCnt;
  logic             sckPhase;
  logic [1:0]       sckSync, ssSync;
  logic             sckPrev;
  logic             doneF, wcolF, modfF;

  logic masterMode, slaveSel, modfEvt, dataWr, statRd, busy, collide;
  logic startMaster, tick, slvEdge, edgeEvt, leading, sampleSide;

  assign masterMode  = cfg.enable & cfg.master;
  assign slaveSel    = cfg.enable & ~cfg.master & ~ssSync[1];
  assign modfEvt     = masterMode & ~ssSync[1];
  assign dataWr      = busWr & (busAddr == ADDR_DATA);
  assign statRd      = busRd & (busAddr == ADDR_STAT);
  assign busy        = (state != ST_IDLE) | slaveSel;
  assign collide     = dataWr & busy;
  assign startMaster = dataWr & ~busy & masterMode & ~modfEvt;
  assign tick        = (state == ST_RUN) & masterMode & (divCnt == divVal);
  assign slvEdge     = slaveSel & (sckSync[1] != sckPrev) & (state != ST_FINISH);
  assign edgeEvt     = masterMode ? tick : slvEdge;
  assign leading     = ~edgeIdx[0];
  assign sampleSide  = leading ^ cfg.cpha;

  always_comb begin
    stb            = '0;
    stb.load       = dataWr & ~busy;
    stb.sample     = edgeEvt & sampleSide;
    stb.shift      = edgeEvt & ~sampleSide & (edgeIdx != '0);
    stb.capture    = (state == ST_FINISH);
    stb.mergeLatch = cfg.cpha;
  end

  assign statusByte  = {doneF, wcolF, 1'b0, modfF, 4'b0000};
  assign irq         = doneF & cfg.irqEn;
  assign sckOut      = cfg.cpol ^ sckPhase;
  assign masterDrive = masterMode;
  assign slaveDrive  = slaveSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      divVal   <= '0;
      state    <= ST_IDLE;
      edgeIdx  <= '0;
      divCnt   <= '0;
      sckPhase <= 1'b0;
      sckSync  <= 2'b00;
      ssSync   <= 2'b11;
      sckPrev  <= 1'b0;
      doneF    <= 1'b0;
      wcolF    <= 1'b0;
      modfF    <= 1'b0;
    end else begin
      sckSync <= {sckSync[0], sckIn};
      ssSync  <= {ssSync[0], ssIn};
      sckPrev <= sckSync[1];
      if (busWr && busAddr == ADDR_CTRL) cfg <= busWdata[$bits(ctrlCfg_t)-1:0];
      if (busWr && busAddr == ADDR_DIV)  divVal <= DIV_W'(busWdata);
      doneF <= (state == ST_FINISH) | (doneF & ~statRd);
      wcolF <= collide | (wcolF & ~statRd);
      modfF <= modfEvt | (modfF & ~statRd);

      unique case (state)
        ST_IDLE: begin
          if (startMaster) begin
            state    <= ST_RUN;
            divCnt   <= '0;
            sckPhase <= 1'b0;
            edgeIdx  <= '0;
          end else if (slvEdge) begin
            state   <= ST_RUN;
            edgeIdx <= IDX_W'(1);
          end else if (!slaveSel) begin
            edgeIdx <= '0;
          end
        end
        ST_RUN: begin
          if (!(masterMode || slaveSel)) begin
            state    <= ST_IDLE;
            edgeIdx  <= '0;
            sckPhase <= 1'b0;
          end else begin
            if (masterMode) begin
              divCnt <= tick ? '0 : divCnt + 1'b1;
              if (tick) sckPhase <= ~sckPhase;
            end
            if (edgeEvt) begin
              if (edgeIdx == LAST_EDGE) begin
                state   <= ST_FINISH;
                edgeIdx <= '0;
              end else begin
                edgeIdx <= edgeIdx + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (modfEvt) begin
        cfg.master <= 1'b0;
        state      <= ST_IDLE;
        edgeIdx    <= '0;
        divCnt     <= '0;
        sckPhase   <= 1'b0;
      end
    end
  end

  // R4: a status read with no new cause leaves every flag clear
  a_r4_flags_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (statRd && state != ST_FINISH && !collide && !modfEvt) |=>
      (statusByte[7] == 1'b0 && statusByte[6] == 1'b0 && statusByte[4] == 1'b0));
  // R7: the fault flag rises together with loss of mastership
  a_r7_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modfF) |-> (!cfg.master && !masterDrive));
  // R9: the interrupt is gone the cycle after a status read
  a_r9_irq_low_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (statRd && state != ST_FINISH) |=> !irq);
  // R10: an idle master holds SCK at the polarity level
  a_r10_idle_sck_level: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && masterMode) |-> (sckOut == cfg.cpol));
  // R8: done rises only in the cycle after the capture strobe
  a_r8_done_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneF) |-> $past(stb.capture));
endmodule

// File: rtl/spi_port.sv
module spi_port import spi_port_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq,
  output logic       sckOut,
  output logic       sckOe,
  output logic       mosiOut,
  output logic       mosiOe,
  input  logic       misoIn,
  input  logic       sckIn,
  input  logic       mosiIn,
  output logic       misoOut,
  output logic       misoOe,
  input  logic       ssIn
);
  localparam int DATA_W = BUS_W;

  dpStrobe_t         stb;
  ctrlCfg_t          cfg;
  logic [DIV_W-1:0]  divVal;
  logic [BUS_W-1:0]  statusByte;
  logic [DATA_W-1:0] rxData;
  logic              serialOut, masterDrive, slaveDrive;

  spi_port_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .sckIn(sckIn), .ssIn(ssIn), .stb(stb), .cfg(cfg),
    .divVal(divVal), .statusByte(statusByte), .irq(irq), .sckOut(sckOut),
    .masterDrive(masterDrive), .slaveDrive(slaveDrive)
  );

  spi_port_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .loadData(busWdata),
    .serialIn(masterDrive ? misoIn : mosiIn), .serialOut(serialOut), .rxData(rxData)
  );

  assign sckOe   = masterDrive;
  assign mosiOe  = masterDrive;
  assign mosiOut = serialOut;
  assign misoOut = serialOut;
  assign misoOe  = slaveDrive;

  always_comb begin
    unique case (busAddr)
      ADDR_DATA: busRdata = rxData;
      ADDR_STAT: busRdata = statusByte;
      ADDR_CTRL: busRdata = BUS_W'(cfg);
      default:   busRdata = BUS_W'(divVal);
    endcase
  end

  // R2: reserved status positions never read as 1
  a_r2_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && busAddr == ADDR_STAT) |-> (busRdata[5] == 1'b0 && busRdata[3:0] == 4'b0000));
endmodule

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq, sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic       sckIn = 1'b0, mosiIn = 1'b0, ssIn = 1'b1;
  logic       misoIn;

  int checks = 0;
  int errors = 0;
  logic cpolTb = 1'b0, cphaTb = 1'b0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;
  assign misoIn = mosiOut;  // loopback in master mode

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sckOut(sckOut),
    .sckOe(sckOe), .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn),
    .sckIn(sckIn), .mosiIn(mosiIn), .misoOut(misoOut), .misoOe(misoOe), .ssIn(ssIn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // monitor: decodes the MOSI line on the sampling edge and pops the scoreboard
  initial begin : monitor
    logic prevSck, prevOe;
    logic [7:0] bits;
    int n;
    prevSck = 1'b0; prevOe = 1'b0; bits = '0; n = 0;
    forever begin
      @(negedge clk);
      if (!sckOe) n = 0;
      else if (prevOe && sckOut != prevSck && ((sckOut != cpolTb) ^ cphaTb)) begin
        bits = {bits[6:0], mosiOut};
        n++;
        if (n == 8) begin
          n = 0;
          if (expQ.size() == 0) chk("R3 unexpected byte on MOSI", bits, 8'hxx);
          else chk("R3 MOSI byte order", bits, expQ.pop_front());
        end
      end
      prevSck = sckOut;
      prevOe  = sckOe;
    end
  end

  task automatic runMaster(input logic [7:0] d, input logic cpol, input logic cpha,
                           input logic [7:0] dv);
    logic [7:0] r;
    int cnt;
    busWrite(2'd2, 8'h00);
    cpolTb = cpol; cphaTb = cpha;
    busWrite(2'd3, dv);
    busWrite(2'd2, {3'b000, 1'b1, cpha, cpol, 1'b1, 1'b1});
    expQ.push_back(d);
    busWrite(2'd0, d);
    cnt = 0;
    while (!irq && cnt < 3000) begin @(negedge clk); cnt++; end
    chk("R3 transfer length", 8'(cnt), 8'(16 * (dv + 1) + 1));
    chk("R10 idle SCK level", {7'b0, sckOut}, {7'b0, cpol});
    busRead(2'd0, r);
    chk("R8 R6 received byte", r, d);
    busRead(2'd1, r);
    chk("R2 done only", r, 8'h80);
    chk("R9 irq low after read", {7'b0, irq}, 8'h00);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin : driver
    logic [7:0] r, misoByte;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    busRead(2'd1, r); chk("R1 status reset", r, 8'h00);
    busRead(2'd2, r); chk("R1 control reset", r, 8'h00);
    busRead(2'd3, r); chk("R1 divider reset", r, 8'h00);
    chk("R1 outputs idle", {4'b0, irq, sckOe, mosiOe, misoOe}, 8'h00);

    // R3 R10: four clock modes, four bytes, four dividers
    runMaster(8'hA5, 1'b0, 1'b0, 8'd0);
    runMaster(8'h3C, 1'b0, 1'b1, 8'd1);
    runMaster(8'h81, 1'b1, 1'b0, 8'd2);
    runMaster(8'h7E, 1'b1, 1'b1, 8'd3);

    // R5 write collision
    busWrite(2'd2, 8'h00);
    cpolTb = 1'b0; cphaTb = 1'b0;
    busWrite(2'd3, 8'd3);
    busWrite(2'd2, 8'h13);
    expQ.push_back(8'h5A);
    busWrite(2'd0, 8'h5A);
    repeat (10) @(negedge clk);
    busWrite(2'd0, 8'hFF);
    cnt = 0;
    while (!irq && cnt < 3000) begin @(negedge clk); cnt++; end
    busRead(2'd0, r); chk("R5 byte in flight kept", r, 8'h5A);
    busRead(2'd1, r); chk("R5 R2 done and collision", r, 8'hC0);
    busRead(2'd1, r); chk("R4 flags cleared by read", r, 8'h00);

    // R9 interrupt disabled
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'd0);
    busWrite(2'd2, 8'h03);
    expQ.push_back(8'hC3);
    busWrite(2'd0, 8'hC3);
    repeat (40) @(negedge clk);
    chk("R9 irq stays low when disabled", {7'b0, irq}, 8'h00);
    busRead(2'd1, r); chk("R9 done still set", r, 8'h80);

    // R7 mode fault
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'd3);
    busWrite(2'd2, 8'h03);
    busWrite(2'd0, 8'h11);
    repeat (10) @(negedge clk);
    ssIn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 SCK and MOSI released", {6'b0, sckOe, mosiOe}, 8'h00);
    busRead(2'd2, r); chk("R7 master bit cleared", r, 8'h01);
    busRead(2'd1, r); chk("R7 fault flag only", r, 8'h10);
    ssIn = 1'b1;
    repeat (80) @(negedge clk);
    busRead(2'd1, r); chk("R7 aborted transfer gives no done", r, 8'h00);

    // R11 slave exchange, mode 0
    busWrite(2'd2, 8'h00);
    busWrite(2'd2, 8'h01);
    busWrite(2'd0, 8'h3C);
    ssIn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 MISO driven when selected", {7'b0, misoOe}, 8'h01);
    misoByte = '0;
    for (int i = 7; i >= 0; i--) begin
      mosiIn = 8'hC6 >> i;
      repeat (6) @(negedge clk);
      misoByte = {misoByte[6:0], misoOut};
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R11 slave sends byte on MISO", misoByte, 8'h3C);
    busRead(2'd0, r); chk("R11 R8 slave received byte", r, 8'hC6);
    busRead(2'd1, r); chk("R8 slave done flag", r, 8'h80);
    ssIn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", 8'(expQ.size()), 8'h00);
    finishRun();
  end
endmodule